// File: doc/BRIEF.md
# Base-N Pulse Accumulator Adder

This block models a single-digit counting cell whose base N can be set anywhere from 2 to 512. The cell holds a level that steps up by one for each pulse it receives. From outside, the cell can only be seen through one flag, which is raised once the level reaches N. The levels 0 to N-1 all look the same. A sequencing controller wraps the cell and turns it into a one-digit adder that works directly in base N.

For an addition, the controller clears the cell and sends a burst of pulses equal to the first operand, then a burst equal to the second. Whenever the flag rises during a burst, the cell is cleared, a carry is recorded, and the remaining pulses continue. The stored digit is then recovered destructively: pulses are sent until the flag rises, and the result is the base minus the number of pulses that were needed.

The cell keeps its level between operations, so separate operations can accumulate into it and read it out later. Operands and bases outside the legal range are refused without any effect on the cell.

Top module: `pulse_accum_adder`

## Requirements
- R1: After reset the cell level is 0, `switched` is 0, and both `busy` and `done` are 0.
- R2: `switched` is 1 exactly when the pulses applied since the last clear number at least the base; levels 0 to base-1 leave it at 0.
- R3: Operation code 0 (add) clears the cell, applies opA and then opB pulses, and reads the digit back. It reports `result` = (opA+opB) mod base, and `carry` = 1 exactly when opA+opB >= base.
- R4: A readout pulses the cell until `switched` rises and reports base minus the pulses counted. The cell is left switched afterwards.
- R5: Operation code 2 (read) started while the cell is already switched reports 0 after zero pulses. `done` appears on the second clock edge after the start edge.
- R6: Operation code 1 (accumulate) applies opA pulses on top of the stored level without clearing it first. If the level reaches the base, the cell is cleared, `carry` is 1, and the remaining pulses continue. `result` is 0.
- R7: If a used operand is >= base, or the base lies outside 2..512, the operation raises `rangeErr` together with `done` and leaves the cell level unchanged. Add uses both operands; accumulate uses opA.
- R8: Operation code 3 (clear) sets the cell level to 0 in one command cycle.
- R9: The two cell commands, pulse and clear, are never issued in the same cycle. A pulse sent to a switched cell leaves its level unchanged.
- R10: The bases 2 and 512 give correct sums and carries.
- R11: `done` is a one-cycle pulse. A `start` that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken while idle) |
| op | input | 2 | Operation: 0 add, 1 accumulate, 2 read, 3 clear |
| base | input | 10 | Base N for this operation |
| opA | input | 10 | First operand / accumulate amount |
| opB | input | 10 | Second operand (add only) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Digit recovered by readout |
| carry | output | 1 | Overflow seen during this operation |
| rangeErr | output | 1 | Operation refused for range |
| switched | output | 1 | Threshold flag of the cell |

## Verification
The assertions check several properties on every cycle:
- the cell steps by exactly one per accepted pulse, and holds otherwise;
- a clear empties the cell, and a pulse to a switched cell leaves it unchanged;
- pulse and clear are never issued together;
- `done` lasts a single cycle;
- a refused operation issues no command.

Only the bench scenarios can show the arithmetic itself. That covers sums with and without carry, the sum that lands exactly on the base, and persistence across separate accumulate and read operations. It also covers the zero-pulse read of an already switched cell, the smallest and largest bases, and the preserved level after a refused operation.

// File: rtl/accum_pkg.sv
package accum_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ACC  = 2'd1,
    OP_READ = 2'd2,
    OP_CLR  = 2'd3
  } opCode_t;

  // strobes from the sequencer to the cell
  typedef struct packed {
    logic pulse;
    logic clear;
  } cellCmd_t;
endpackage

// File: rtl/accum_cell.sv
module accum_cell
  import accum_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  cellCmd_t     cmd,
  input  logic [W-1:0] limit,
  output logic         switched
);
  logic [W-1:0] level;

  assign switched = (level >= limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= '0;
    end else if (cmd.clear && !cmd.pulse) begin
      level <= '0;
    end else if (cmd.pulse && !cmd.clear && !switched) begin
      level <= level + W'(1);
    end
    // pulse and clear together: rejected, level kept
  end

  // R2: an accepted pulse moves the level up by exactly one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.pulse && !cmd.clear && !switched) |=> (level == $past(level) + W'(1)));

  // R2: with no command the level is retained
  a_r2_retain: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.pulse && !cmd.clear) |=> $stable(level));

  // R8: a clear empties the cell in one cycle
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.clear && !cmd.pulse) |=> (level == '0));

  // R9: a pulse to a switched cell changes nothing
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.pulse && !cmd.clear && switched) |=> $stable(level));
endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
#(
  parameter int W        = 10,
  parameter int MAX_BASE = 512
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] base,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         switched,
  output cellCmd_t     cmd,
  output logic [W-1:0] baseQ,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         carry,
  output logic         rangeErr
);
  typedef enum logic [2:0] {S_IDLE, S_CLR, S_RUNA, S_RUNB, S_READ, S_FIN} state_t;

  state_t       st;
  opCode_t      opQ;
  logic [W-1:0] remA, remB, readCnt;
  logic         baseOk, inRange;

  always_comb begin
    baseOk = (base >= W'(2)) && (base <= W'(MAX_BASE));
    case (opCode_t'(op))
      OP_ADD:  inRange = baseOk && (opA < base) && (opB < base);
      OP_ACC:  inRange = baseOk && (opA < base);
      default: inRange = baseOk;
    endcase
  end

  always_comb begin
    cmd = '0;
    case (st)
      S_CLR:  cmd.clear = 1'b1;
      S_RUNA: begin
        if (switched)          cmd.clear = 1'b1;
        else if (remA != '0)   cmd.pulse = 1'b1;
      end
      S_RUNB: begin
        if (switched)          cmd.clear = 1'b1;
        else if (remB != '0)   cmd.pulse = 1'b1;
      end
      S_READ: cmd.pulse = !switched;
      default: ;
    endcase
  end

  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= S_IDLE;
      opQ      <= OP_ADD;
      baseQ    <= W'(MAX_BASE);
      remA     <= '0;
      remB     <= '0;
      readCnt  <= '0;
      result   <= '0;
      carry    <= 1'b0;
      rangeErr <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          opQ      <= opCode_t'(op);
          result   <= '0;
          carry    <= 1'b0;
          rangeErr <= 1'b0;
          if (!inRange) begin
            rangeErr <= 1'b1;
            st       <= S_FIN;
          end else begin
            baseQ   <= base;
            remA    <= opA;
            remB    <= opB;
            readCnt <= '0;
            case (opCode_t'(op))
              OP_ACC:  st <= S_RUNA;
              OP_READ: st <= S_READ;
              default: st <= S_CLR;
            endcase
          end
        end
        S_CLR: st <= (opQ == OP_ADD) ? S_RUNA : S_FIN;
        S_RUNA: begin
          if (switched)        carry <= 1'b1;
          else if (remA != '0) remA  <= remA - W'(1);
          else                 st    <= (opQ == OP_ADD) ? S_RUNB : S_FIN;
        end
        S_RUNB: begin
          if (switched)        carry <= 1'b1;
          else if (remB != '0) remB  <= remB - W'(1);
          else                 st    <= S_READ;
        end
        S_READ: begin
          if (switched) begin
            result <= (readCnt == '0) ? '0 : baseQ - readCnt;
            st     <= S_FIN;
          end else begin
            readCnt <= readCnt + W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9: the two cell commands are exclusive
  a_r9_cmd_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.pulse && cmd.clear));

  // R11: completion is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a refused operation drives no command to the cell
  a_r7_refused_quiet: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> (!cmd.pulse && !cmd.clear));

  // R3/R6: carry only arises from operations that apply operand pulses
  a_r3_carry_source: assert property (@(posedge clk) disable iff (!rstN)
    carry |-> ((opQ == OP_ADD) || (opQ == OP_ACC)));
endmodule

// File: rtl/pulse_accum_adder.sv
module pulse_accum_adder
  import accum_pkg::*;
#(
  parameter int MAX_BASE = 512,
  localparam int W = $clog2(MAX_BASE + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] base,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         carry,
  output logic         rangeErr,
  output logic         switched
);
  cellCmd_t     cellCmd;
  logic [W-1:0] cellLimit;

  accum_ctrl #(.W(W), .MAX_BASE(MAX_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .base(base),
    .opA(opA), .opB(opB), .switched(switched), .cmd(cellCmd),
    .baseQ(cellLimit), .busy(busy), .done(done), .result(result),
    .carry(carry), .rangeErr(rangeErr)
  );

  accum_cell #(.W(W)) u_cell (
    .clk(clk), .rstN(rstN), .cmd(cellCmd), .limit(cellLimit),
    .switched(switched)
  );
endmodule

// File: tb/sim_pulse_accum_adder.sv
`timescale 1ns/1ps
module sim_pulse_accum_adder;
  localparam int W = 10;
  localparam int NV = 23;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = 2'd0;
  logic [W-1:0] base = 10'd10, opA = '0, opB = '0;
  logic         busy, done, carry, rangeErr, switched;
  logic [W-1:0] result;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  int lat;

  always #2.5 clk = ~clk;

  pulse_accum_adder u0 (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .base(base),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .result(result),
    .carry(carry), .rangeErr(rangeErr), .switched(switched)
  );

  // {op, base, opA, opB, expResult, expCarry, expErr}; run in order, cell persists
  localparam logic [43:0] VEC [NV] = '{
    {2'd3, 10'd10,  10'd0,   10'd0,   10'd0,   1'b0, 1'b0},  // R8
    {2'd0, 10'd10,  10'd1,   10'd3,   10'd4,   1'b0, 1'b0},  // R3
    {2'd0, 10'd10,  10'd7,   10'd6,   10'd3,   1'b1, 1'b0},  // R3 carry
    {2'd0, 10'd10,  10'd7,   10'd3,   10'd0,   1'b1, 1'b0},  // R3 lands on base
    {2'd0, 10'd10,  10'd0,   10'd0,   10'd0,   1'b0, 1'b0},  // R4 full read
    {2'd0, 10'd10,  10'd9,   10'd9,   10'd8,   1'b1, 1'b0},
    {2'd0, 10'd6,   10'd3,   10'd1,   10'd4,   1'b0, 1'b0},
    {2'd0, 10'd2,   10'd1,   10'd1,   10'd0,   1'b1, 1'b0},  // R10
    {2'd0, 10'd2,   10'd1,   10'd0,   10'd1,   1'b0, 1'b0},  // R10
    {2'd0, 10'd512, 10'd511, 10'd511, 10'd510, 1'b1, 1'b0},  // R10
    {2'd0, 10'd512, 10'd300, 10'd100, 10'd400, 1'b0, 1'b0},  // R10
    {2'd3, 10'd10,  10'd0,   10'd0,   10'd0,   1'b0, 1'b0},
    {2'd1, 10'd10,  10'd3,   10'd0,   10'd0,   1'b0, 1'b0},  // R6
    {2'd1, 10'd10,  10'd4,   10'd0,   10'd0,   1'b0, 1'b0},  // R6
    {2'd2, 10'd10,  10'd0,   10'd0,   10'd7,   1'b0, 1'b0},  // R4
    {2'd2, 10'd10,  10'd0,   10'd0,   10'd0,   1'b0, 1'b0},  // R5
    {2'd3, 10'd10,  10'd0,   10'd0,   10'd0,   1'b0, 1'b0},
    {2'd1, 10'd10,  10'd7,   10'd0,   10'd0,   1'b0, 1'b0},
    {2'd1, 10'd10,  10'd6,   10'd0,   10'd0,   1'b1, 1'b0},  // R6 carry
    {2'd2, 10'd10,  10'd0,   10'd0,   10'd3,   1'b0, 1'b0},
    {2'd0, 10'd10,  10'd10,  10'd0,   10'd0,   1'b0, 1'b1},  // R7
    {2'd0, 10'd1,   10'd0,   10'd0,   10'd0,   1'b0, 1'b1},  // R7
    {2'd0, 10'd513, 10'd0,   10'd0,   10'd0,   1'b0, 1'b1}   // R7
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drives one operation, returns negedges from start to done
  task automatic runOp(input logic [1:0] o, input int b, input int a, input int c,
                       output int waited);
    @(negedge clk);
    op = o; base = W'(b); opA = W'(a); opB = W'(c); start = 1'b1;
    waited = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      waited++;
    end while (!done && waited < 5000);
  endtask

  function automatic string tagOf(input logic [1:0] o, input int b, input logic e);
    if (e) return "R7";
    if (b == 2 || b == 512) return "R10";
    case (o)
      2'd0: return "R3";
      2'd1: return "R6";
      2'd2: return "R4";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 switched", int'(switched), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] vo;
      int vb, va, vc, vr;
      logic vcar, verr;
      {vo, vb[9:0], va[9:0], vc[9:0], vr[9:0], vcar, verr} = VEC[i];
      vb = vb & 1023; va = va & 1023; vc = vc & 1023; vr = vr & 1023;
      runOp(vo, vb, va, vc, lat);
      chk({tagOf(vo, vb, verr), " result"}, int'(result), vr);
      chk({tagOf(vo, vb, verr), " carry"}, int'(carry), int'(vcar));
      chk({tagOf(vo, vb, verr), " rangeErr"}, int'(rangeErr), int'(verr));
      if (vo == 2'd0 && !verr) chk("R4 left switched", int'(switched), 1);
      if (i == 15) chk("R5 zero-pulse latency", lat, 2);
      @(negedge clk);
      chk("R11 done single cycle", int'(done), 0);
    end

    // R2: level base-1 still reads not switched, and reads back correctly
    runOp(2'd3, 4, 0, 0, lat);
    runOp(2'd1, 4, 3, 0, lat);
    chk("R2 level N-1 not switched", int'(switched), 0);
    runOp(2'd2, 4, 0, 0, lat);
    chk("R2 read of level 3 base 4", int'(result), 3);
    chk("R2 read latency 1 pulse", lat, 3);

    // R7: refused operation leaves the stored level intact
    runOp(2'd3, 10, 0, 0, lat);
    runOp(2'd1, 10, 5, 0, lat);
    runOp(2'd0, 10, 2, 12, lat);
    chk("R7 refused flagged", int'(rangeErr), 1);
    chk("R7 refused not switched", int'(switched), 0);
    runOp(2'd2, 10, 0, 0, lat);
    chk("R7 level preserved", int'(result), 5);

    // R8: clear empties a partly filled cell
    runOp(2'd1, 10, 6, 0, lat);
    runOp(2'd3, 10, 0, 0, lat);
    runOp(2'd1, 10, 2, 0, lat);
    runOp(2'd2, 10, 0, 0, lat);
    chk("R8 clear then accumulate 2", int'(result), 2);

    // R11: start while busy is ignored
    @(negedge clk);
    op = 2'd0; base = 10'd512; opA = 10'd300; opB = 10'd100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    op = 2'd3; base = 10'd10; opA = 10'd1; opB = 10'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    chk("R11 busy start ignored result", int'(result), 400);
    @(negedge clk);
    chk("R11 idle after busy start", int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule